// File: doc/BRIEF.md
# Branch Trace Buffer with Compression

This block sits next to a processor core and records taken changes of program flow as pairs of addresses: the source PC and the destination PC. The pairs go into a 16-entry circular store. The core presents one branch event per cycle. Each event carries both PCs, a flag that marks a hardware-loop iteration, and the interrupt level the core is running at. The block filters each event against the control settings and that level. A branch identical to the newest stored entry, or to the one before it, can be folded into that entry by setting bit 0 of one of its PCs, so the repeat takes no new slot.

Software uses three word registers: control, status and data. Status returns the number of held entries. Data pops entries newest first, destination half before source half. When the store is full, one control bit selects what the block does with another event. It either evicts the oldest entry, or it stores nothing and pulses an overflow-exception request to the core's exception logic.

Top module: `btb_top`

## Requirements
- R1: After reset, the control register reads 0, status reads 0, a data read returns 0, and `ovf_exc_o` is low.
- R2: Control sits at offset 0x000. Bit 0 is power, bit 1 is enable, bit 2 is overflow-exception select, bit 3 is one-level compression and bit 4 is two-level compression. Bits 31:5 read 0. Writes to status (0x004), to data (0x100) and to any other offset change nothing. A read of any other offset returns 0.
- R3: An event is considered only while both power (bit 0) and enable (bit 1) are set. Otherwise it changes nothing and raises no request.
- R4: An event with `ev_hwloop_i` high is never recorded. An event at level 1 (the reset level) is never recorded.
- R5: With overflow-exception select set, events at levels 0 to 3 (emulation, reset, NMI, exception) are dropped without a request. Levels 4 to 15 are handled normally.
- R6: An accepted event that finds 16 entries while overflow-exception select is set stores nothing and changes no entry. `ovf_exc_o` is high for exactly the one cycle after the clock edge that took the event.
- R7: An accepted event that finds 16 entries while overflow-exception select is clear evicts the oldest entry and stores the new one. The count stays 16.
- R8: With one-level compression on and at least one entry held, an event whose source and destination equal those of the newest entry is not stored; bits 0 are ignored in the comparison. Instead, bit 0 of that entry's destination is set.
- R9: With two-level compression on, at least two entries held, and R8 not applying, an event that matches the second-newest entry in the same way is not stored. Instead, bit 0 of that entry's source is set.
- R10: A data read (0x100) of an empty store returns 0 and changes nothing. Otherwise reads alternate. The first returns the newest entry's destination. The second returns its source and removes the entry.
- R11: A status read (0x004) returns the entry count, at most 16.
- R12: When a data read that removes an entry and an accepted event fall in the same cycle, the removal takes effect first. The event then sees the reduced store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Branch event present this cycle |
| ev_src_i | input | 32 | Source PC of the branch |
| ev_dst_i | input | 32 | Destination PC of the branch |
| ev_hwloop_i | input | 1 | Branch is a hardware-loop iteration |
| ev_level_i | input | 4 | Current interrupt level; 0 emulation, 1 reset, 2 NMI, 3 exception, higher numbers lower priority |
| reg_read_i | input | 1 | Register read strobe |
| reg_write_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| ovf_exc_o | output | 1 | One-cycle overflow-exception request |

## Verification
The checker holds several properties on every cycle:
- The count never exceeds the depth.
- A gated-off, loop-flagged or reset-level event leaves the count unchanged and raises no request.
- Every request traces back to an overflow-mode event that met a full store, and it leaves the count unchanged.
- An empty data read returns 0.

Other behaviour can be shown only by the bench scenarios, which check the contents actually read out:
- the newest-first, destination-then-source order;
- which PC gets its bit 0 set by each compression level;
- eviction of the oldest entry;
- the pop-before-push ordering when a read and an event share a cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned C_PWR  = 0;
  localparam int unsigned C_EN   = 1;
  localparam int unsigned C_OVF  = 2;
  localparam int unsigned C_CMP1 = 3;
  localparam int unsigned C_CMP2 = 4;

  typedef struct packed {
    logic [PC_W-1:0] src;
    logic [PC_W-1:0] dst;
  } trace_ent_t;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_STAT, SEL_DATA} reg_sel_e;
endpackage

// File: rtl/btb_gate.sv
module btb_gate
  import btb_pkg::*;
#(
  parameter int unsigned LVL_W       = 4,
  parameter int unsigned LVL_RESET   = 1,
  parameter int unsigned LVL_EXC_MAX = 3
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              valid_i,
  input  logic              hwloop_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              accept_o
);
  logic on_w, lvl_ok_w, hi_prio_w;

  always_comb begin
    on_w      = ctrl_i[C_PWR] & ctrl_i[C_EN];
    hi_prio_w = level_i <= LVL_W'(LVL_EXC_MAX);
    lvl_ok_w  = (level_i != LVL_W'(LVL_RESET)) & ~(ctrl_i[C_OVF] & hi_prio_w);
    accept_o  = valid_i & on_w & ~hwloop_i & lvl_ok_w;
  end
endmodule

// File: rtl/btb_ring.sv
module btb_ring
  import btb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_rd_i,
  output logic [PC_W-1:0]  data_word_o,
  input  logic             evt_i,
  input  logic [PC_W-1:0]  src_i,
  input  logic [PC_W-1:0]  dst_i,
  input  logic             ovf_mode_i,
  input  logic             cmp1_i,
  input  logic             cmp2_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             exc_o
);
  trace_ent_t       ent_q [DEPTH];
  logic [IDX_W-1:0] top_q, top_rd, eff_top, newest_idx, second_idx;
  logic [CNT_W-1:0] cnt_q, eff_cnt;
  logic             mid_q, exc_q;
  logic             empty, rd_live, pop, full, hit1, hit2, exc, live, store, mark_dst, mark_src;

  function automatic logic pc_match(trace_ent_t e, logic [PC_W-1:0] s, logic [PC_W-1:0] d);
    return (e.src[PC_W-1:1] == s[PC_W-1:1]) && (e.dst[PC_W-1:1] == d[PC_W-1:1]);
  endfunction

  always_comb begin
    empty       = cnt_q == '0;
    rd_live     = data_rd_i & ~empty;
    pop         = rd_live & mid_q;
    top_rd      = top_q - IDX_W'(1);
    data_word_o = empty ? '0 : (mid_q ? ent_q[top_rd].src : ent_q[top_rd].dst);
    // pop first, then the event sees the reduced store
    eff_top     = pop ? top_rd : top_q;
    eff_cnt     = cnt_q - CNT_W'(pop);
    full        = eff_cnt == CNT_W'(DEPTH);
    newest_idx  = eff_top - IDX_W'(1);
    second_idx  = eff_top - IDX_W'(2);
    hit1        = cmp1_i & (eff_cnt != '0) & pc_match(ent_q[newest_idx], src_i, dst_i);
    hit2        = cmp2_i & (eff_cnt >= CNT_W'(2)) & ~hit1 & pc_match(ent_q[second_idx], src_i, dst_i);
    exc         = evt_i & full & ovf_mode_i;
    live        = evt_i & ~exc;
    store       = live & ~hit1 & ~hit2;
    mark_dst    = live & hit1;
    mark_src    = live & hit2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      cnt_q <= '0;
      mid_q <= 1'b0;
      exc_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      if (rd_live) mid_q <= ~mid_q;
      top_q <= eff_top + IDX_W'(store);
      cnt_q <= eff_cnt + CNT_W'(store & ~full);
      exc_q <= exc;
      for (int i = 0; i < DEPTH; i++) begin
        if (store && eff_top == IDX_W'(i)) begin
          ent_q[i].src <= src_i;
          ent_q[i].dst <= dst_i;
        end else if (mark_dst && newest_idx == IDX_W'(i)) begin
          ent_q[i].dst[0] <= 1'b1;
        end else if (mark_src && second_idx == IDX_W'(i)) begin
          ent_q[i].src[0] <= 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign exc_o = exc_q;
endmodule

// File: rtl/btb_regs.sv
module btb_regs
  import btb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned STAT_CAP = 16,
  parameter int unsigned CTRL_OFF = 'h000,
  parameter int unsigned STAT_OFF = 'h004,
  parameter int unsigned DATA_OFF = 'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PC_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PC_W-1:0]   data_word_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              data_rd_o,
  output logic [PC_W-1:0]   rdata_o
);
  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  stat_w;
  logic              wdata_unused;

  assign wdata_unused = ^wdata_i[PC_W-1:CTRL_W];

  always_comb begin
    if (addr_i == ADDR_W'(CTRL_OFF))      sel = SEL_CTRL;
    else if (addr_i == ADDR_W'(STAT_OFF)) sel = SEL_STAT;
    else if (addr_i == ADDR_W'(DATA_OFF)) sel = SEL_DATA;
    else                                  sel = SEL_NONE;
    stat_w    = (cnt_i > CNT_W'(STAT_CAP)) ? CNT_W'(STAT_CAP) : cnt_i;
    data_rd_o = rd_i & (sel == SEL_DATA);
    rdata_o   = '0;
    if (rd_i) begin
      case (sel)
        SEL_CTRL: rdata_o = {{(PC_W-CTRL_W){1'b0}}, ctrl_q};
        SEL_STAT: rdata_o = {{(PC_W-CNT_W){1'b0}}, stat_w};
        SEL_DATA: rdata_o = data_word_i;
        default:  rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctrl_q <= '0;
    else if (wr_i && sel == SEL_CTRL)   ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned STAT_CAP    = 16,
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned LVL_W       = 4,
  parameter int unsigned LVL_RESET   = 1,
  parameter int unsigned LVL_EXC_MAX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [31:0]       ev_src_i,
  input  logic [31:0]       ev_dst_i,
  input  logic              ev_hwloop_i,
  input  logic [LVL_W-1:0]  ev_level_i,
  input  logic              reg_read_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              ovf_exc_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CTRL_W-1:0] ctrl_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [PC_W-1:0]   data_word_w;
  logic              data_rd_w, accept_w;

  btb_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAT_CAP(STAT_CAP)
  ) u_regs (
    .clk_i, .rst_ni,
    .rd_i(reg_read_i), .wr_i(reg_write_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_i(cnt_w), .data_word_i(data_word_w),
    .ctrl_o(ctrl_w), .data_rd_o(data_rd_w), .rdata_o(reg_rdata_o)
  );

  btb_gate #(
    .LVL_W(LVL_W), .LVL_RESET(LVL_RESET), .LVL_EXC_MAX(LVL_EXC_MAX)
  ) u_gate (
    .ctrl_i(ctrl_w), .valid_i(ev_valid_i), .hwloop_i(ev_hwloop_i),
    .level_i(ev_level_i), .accept_o(accept_w)
  );

  btb_ring #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ring (
    .clk_i, .rst_ni,
    .data_rd_i(data_rd_w), .data_word_o(data_word_w),
    .evt_i(accept_w), .src_i(ev_src_i), .dst_i(ev_dst_i),
    .ovf_mode_i(ctrl_w[C_OVF]), .cmp1_i(ctrl_w[C_CMP1]), .cmp2_i(ctrl_w[C_CMP2]),
    .cnt_o(cnt_w), .exc_o(ovf_exc_o)
  );
endmodule

// File: rtl/btb_chk.sv
module btb_chk
  import btb_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned LVL_RESET = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_valid_i,
  input logic              ev_hwloop_i,
  input logic [LVL_W-1:0]  ev_level_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              data_rd_i,
  input logic [31:0]       reg_rdata_o,
  input logic              ovf_exc_o
);
  // R3
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !(ctrl_i[C_PWR] && ctrl_i[C_EN]) && !data_rd_i) |=> ($stable(cnt_i) && !ovf_exc_o));

  // R4
  loop_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && (ev_hwloop_i || ev_level_i == LVL_W'(LVL_RESET)) && !data_rd_i)
      |=> ($stable(cnt_i) && !ovf_exc_o));

  // R6
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_exc_o |-> $past(ev_valid_i && ctrl_i[C_OVF] && cnt_i == CNT_W'(DEPTH)));

  // R6
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_exc_o |-> (cnt_i == $past(cnt_i)));

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  // R10
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && cnt_i == '0) |-> (reg_rdata_o == 32'h0));
endmodule

bind btb_top btb_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W), .LVL_RESET(LVL_RESET)
) u_chk (
  .clk_i, .rst_ni, .ev_valid_i, .ev_hwloop_i, .ev_level_i,
  .ctrl_i(ctrl_w), .cnt_i(cnt_w), .data_rd_i(data_rd_w), .reg_rdata_o, .ovf_exc_o
);

// File: tb/btb_top_test.sv
`timescale 1ns/1ps
module btb_top_test;
  localparam int D = 16;
  localparam logic [8:0] A_CTRL = 9'h000, A_STAT = 9'h004, A_DATA = 9'h100;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_hw = 0;
  logic [31:0] ev_src = 0, ev_dst = 0, wdata = 0;
  logic [3:0] ev_lvl = 0;
  logic rd = 0, wr = 0;
  logic [8:0] addr = 0;
  logic [31:0] rdata;
  logic exc;

  int checks = 0, fails = 0;
  logic [31:0] ms [D];
  logic [31:0] md [D];
  int mc = 0;
  bit mm = 0;
  logic [4:0] mctrl = 0;

  always #2.5 clk = ~clk;

  btb_top uut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_src_i(ev_src), .ev_dst_i(ev_dst),
    .ev_hwloop_i(ev_hw), .ev_level_i(ev_lvl), .reg_read_i(rd), .reg_write_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ovf_exc_o(exc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit pcm(logic [31:0] a, logic [31:0] b);
    return a[31:1] == b[31:1];
  endfunction

  // reference model of one cycle, built from the requirements
  task automatic model(input bit r, input bit w, input logic [8:0] a, input logic [31:0] wd,
                       input bit ev, input logic [31:0] s, input logic [31:0] d, input bit hw,
                       input logic [3:0] lv, output logic [31:0] erd, output bit eexc);
    bit acc;
    erd = 0; eexc = 0;
    if (r) begin
      if (a == A_CTRL) erd = {27'd0, mctrl};
      else if (a == A_STAT) erd = (mc > 16) ? 32'd16 : 32'(mc);
      else if (a == A_DATA) erd = (mc == 0) ? 32'd0 : (mm ? ms[mc-1] : md[mc-1]);
      if (a == A_DATA && mc != 0) begin
        if (mm) mc--;
        mm = !mm;
      end
    end
    acc = ev && mctrl[0] && mctrl[1] && !hw && lv != 1 && !(mctrl[2] && lv <= 3);
    if (acc) begin
      if (mc == D && mctrl[2]) eexc = 1;
      else if (mctrl[3] && mc >= 1 && pcm(ms[mc-1], s) && pcm(md[mc-1], d)) md[mc-1][0] = 1'b1;
      else if (mctrl[4] && mc >= 2 && pcm(ms[mc-2], s) && pcm(md[mc-2], d)) ms[mc-2][0] = 1'b1;
      else begin
        if (mc == D) begin
          for (int k = 0; k < D-1; k++) begin ms[k] = ms[k+1]; md[k] = md[k+1]; end
          mc--;
        end
        ms[mc] = s; md[mc] = d; mc++;
      end
    end
    if (w && a == A_CTRL) mctrl = wd[4:0];
  endtask

  task automatic cyc(input bit r, input bit w, input logic [8:0] a, input logic [31:0] wd,
                     input bit ev, input logic [31:0] s, input logic [31:0] d, input bit hw,
                     input logic [3:0] lv, input string tag);
    logic [31:0] erd; bit eexc;
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = wd; ev_valid = ev; ev_src = s; ev_dst = d; ev_hw = hw; ev_lvl = lv;
    model(r, w, a, wd, ev, s, d, hw, lv, erd, eexc);
    #1;
    if (r) check(rdata === erd, tag, rdata, erd);
    @(posedge clk);
    #1;
    rd = 0; wr = 0; ev_valid = 0;
    check(exc === eexc, tag, {31'd0, exc}, {31'd0, eexc});
  endtask

  task automatic rreg(input logic [8:0] a, input string tag);
    cyc(1, 0, a, 0, 0, 0, 0, 0, 4'd8, tag);
  endtask
  task automatic wreg(input logic [8:0] a, input logic [31:0] v, input string tag);
    cyc(0, 1, a, v, 0, 0, 0, 0, 4'd8, tag);
  endtask
  task automatic evt(input logic [31:0] s, input logic [31:0] d, input bit hw, input logic [3:0] lv, input string tag);
    cyc(0, 0, 0, 0, 1, s, d, hw, lv, tag);
  endtask
  task automatic drain(input string tag);
    for (int k = 0; k < 2*D + 1; k++) rreg(A_DATA, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rreg(A_CTRL, "R1"); rreg(A_STAT, "R1"); rreg(A_DATA, "R1");
    // R2 control bits and ignored writes
    wreg(A_CTRL, 32'hFFFF_FFFF, "R2"); rreg(A_CTRL, "R2");
    wreg(A_STAT, 32'h55, "R2"); wreg(A_DATA, 32'h77, "R2"); wreg(9'h008, 32'h1, "R2");
    rreg(A_STAT, "R2"); rreg(9'h008, "R2"); rreg(A_CTRL, "R2");
    // R3 power and enable gating
    wreg(A_CTRL, 32'h1, "R3"); evt(32'h100, 32'h200, 0, 4'd8, "R3"); rreg(A_STAT, "R3");
    wreg(A_CTRL, 32'h2, "R3"); evt(32'h100, 32'h200, 0, 4'd8, "R3"); rreg(A_STAT, "R3");
    wreg(A_CTRL, 32'h3, "R3"); evt(32'h100, 32'h200, 0, 4'd8, "R3"); rreg(A_STAT, "R3");
    // R10 readout order, empty read
    rreg(A_DATA, "R10"); rreg(A_DATA, "R10"); rreg(A_STAT, "R10"); rreg(A_DATA, "R10");
    // R4 loop and reset-level filtering
    evt(32'h300, 32'h400, 1, 4'd8, "R4"); evt(32'h300, 32'h400, 0, 4'd1, "R4");
    evt(32'h310, 32'h410, 0, 4'd0, "R4"); rreg(A_STAT, "R4"); drain("R4");
    // R5 high-priority levels dropped in overflow mode
    wreg(A_CTRL, 32'h7, "R5");
    evt(32'h500, 32'h600, 0, 4'd0, "R5"); evt(32'h500, 32'h600, 0, 4'd2, "R5");
    evt(32'h500, 32'h600, 0, 4'd3, "R5"); evt(32'h504, 32'h604, 0, 4'd4, "R5");
    rreg(A_STAT, "R5"); drain("R5");
    // R7 and R11 wrap with eviction
    wreg(A_CTRL, 32'h3, "R7");
    for (int k = 0; k < 20; k++) evt(32'h1000 + 32'(k*16), 32'h8000 + 32'(k*16), 0, 4'd9, "R7");
    rreg(A_STAT, "R11"); drain("R7");
    // R6 full store with overflow exception
    for (int k = 0; k < D; k++) evt(32'h2000 + 32'(k*8), 32'h9000 + 32'(k*8), 0, 4'd9, "R6");
    wreg(A_CTRL, 32'h7, "R6");
    evt(32'h2000 + 32'((D-1)*8), 32'h9000 + 32'((D-1)*8), 0, 4'd9, "R6");
    evt(32'hAAAA, 32'hBBBB, 0, 4'd9, "R6"); rreg(A_STAT, "R6"); drain("R6");
    // R8 one-level compression
    wreg(A_CTRL, 32'hB, "R8");
    evt(32'h40, 32'h80, 0, 4'd8, "R8"); evt(32'h41, 32'h80, 0, 4'd8, "R8");
    rreg(A_STAT, "R8"); drain("R8");
    // R9 two-level compression
    wreg(A_CTRL, 32'h13, "R9");
    evt(32'h40, 32'h80, 0, 4'd8, "R9"); evt(32'h50, 32'h90, 0, 4'd8, "R9");
    evt(32'h40, 32'h81, 0, 4'd8, "R9"); rreg(A_STAT, "R9"); drain("R9");
    // R12 popping read and event in one cycle
    wreg(A_CTRL, 32'hB, "R12");
    evt(32'h60, 32'hA0, 0, 4'd8, "R12"); evt(32'h70, 32'hB0, 0, 4'd8, "R12");
    rreg(A_DATA, "R12");
    cyc(1, 0, A_DATA, 0, 1, 32'h60, 32'hA0, 0, 4'd8, "R12");
    rreg(A_STAT, "R12"); drain("R12");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] s = 32'h3000 + 32'($urandom_range(0, 3) * 4) + 32'($urandom_range(0, 1));
      logic [31:0] d = 32'h7000 + 32'($urandom_range(0, 3) * 4) + 32'($urandom_range(0, 1));
      if (op < 5) evt(s, d, $urandom_range(0, 7) == 0, 4'($urandom_range(0, 15)), "R8");
      else if (op < 7) rreg(A_DATA, "R10");
      else if (op < 8) rreg(A_STAT, "R11");
      else if (op < 9) cyc(1, 0, A_DATA, 0, 1, s, d, 0, 4'd9, "R12");
      else wreg(A_CTRL, {27'd0, 3'($urandom), ($urandom_range(0, 7) != 0) ? 2'b11 : 2'($urandom)}, "R9");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule